// File: doc/BRIEF.md
# Credit-Gated Ingress Queue Scheduler

This block is the send-side decision logic for one input port of a switch that buffers cells both at its inputs and at each crosspoint of the core. It keeps no cells. It counts them: one occupancy counter per (destination, class) queue, and one credit counter per destination crosspoint buffer. Upstream logic reports each cell it stores through an enqueue strobe. The core returns a credit each time a crosspoint buffer frees a slot. Each cycle the block may name one queue whose head cell goes onto the link.

A queue can be picked only if it holds a cell and its destination holds a credit. Classes are served in strict priority, and class 0 is the most urgent. Inside the winning class, destinations take turns through a per-class round-robin pointer. Each credit pool starts full at the round-trip depth, 64 cells by default. At that depth one input can drive any single output at full rate when no other input is competing. A credit returned to a full pool is discarded and flagged.

The selection is purely combinational from registered state and `link_ready`. A grant is therefore seen in the same cycle it is issued, and its bookkeeping updates at the following clock edge. The block has no sequencing state machine: its only state is the counters and the round-robin pointers.

Top module: `vsched_ingress`

## Requirements
- R1: After reset every credit counter holds CREDIT_INIT, every queue is empty, `grant_valid` is low and `cred_err` is low.
- R2: Class codes run 0 to 7 and 0 is the highest priority. `grant_cls` is always the lowest-numbered class that has at least one eligible queue, where eligible means a nonzero occupancy and a nonzero credit for that destination.
- R3: No grant is ever issued toward a destination whose credit counter is zero. When a destination runs out of credit, a queue of a lower-priority class toward another destination with credit is served instead.
- R4: Each grant lowers its destination's credit by one. Each credit return (`cred_valid` with `cred_dst`) raises that destination's credit by one.
- R5: Within a class the search starts at that class's pointer, which resets to destination 0. After a grant to destination d, the pointer moves to (d+1) mod N_DST.
- R6: A credit counter never exceeds CREDIT_INIT. A return to a counter already at CREDIT_INIT leaves it unchanged, and `cred_err` goes high for exactly the next cycle.
- R7: A grant and a credit return for the same destination in the same cycle leave that destination's credit unchanged.
- R8: An enqueue raises the addressed queue's occupancy by one and a grant lowers it by one. Both in the same cycle on the same queue leave it unchanged. No grant is issued for an empty queue.
- R9: At most one grant is issued per cycle, and only while `link_ready` is high. Round-robin pointers move only on a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A cell was stored for queue (enq_dst, enq_cls) |
| enq_dst | input | DW | Destination of the stored cell |
| enq_cls | input | 3 | Class of the stored cell |
| cred_valid | input | 1 | One credit returned by a crosspoint buffer |
| cred_dst | input | DW | Destination whose credit is returned |
| link_ready | input | 1 | The link to the core can accept a cell this cycle |
| grant_valid | output | 1 | A cell is sent this cycle |
| grant_dst | output | DW | Destination of the granted queue |
| grant_cls | output | 3 | Class of the granted queue |
| cred_err | output | 1 | High for one cycle after a credit return was discarded at the cap |

## Verification
The bench drives one destination until its credit is exhausted and counts the grants. An off-by-one in the initial load or in the zero test gives the wrong count, and a scheduler that ignores credit keeps sending. It then returns credit at the cap. A design without the clamp accepts a 65th cell, and one without the flag stays silent. A grant and a return that coincide, and an enqueue and a grant that coincide, are each followed by a drain. An adder or subtractor that wins instead of cancelling shows up as an extra or a missing grant. Mixed-class loads expose a reversed priority order, and an even spread over all destinations exposes a round-robin pointer that skips or repeats a destination.

// File: rtl/vsched_pkg.sv
package vsched_pkg;
    localparam int unsigned NUM_CLS = 8;
    localparam int unsigned CLS_W   = 3;
endpackage

// File: rtl/vsched_credit_bank.sv
module vsched_credit_bank #(
    parameter int unsigned N_DST       = 4,
    parameter int unsigned CREDIT_INIT = 64,
    localparam int unsigned DW = (N_DST > 1) ? $clog2(N_DST) : 1,
    localparam int unsigned CW = $clog2(CREDIT_INIT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_en,
    input  logic [DW-1:0]       take_dst,
    input  logic                ret_en,
    input  logic [DW-1:0]       ret_dst,
    output logic [N_DST*CW-1:0] credit_flat,
    output logic [N_DST-1:0]    has_credit,
    output logic                ovf_err
);
    localparam logic [CW-1:0] FULL = CW'(CREDIT_INIT);

    logic [N_DST-1:0] ovf_hit;

    for (genvar d = 0; d < N_DST; d++) begin : g_pool
        logic [CW-1:0] cnt_q;
        logic          take_hit;
        logic          ret_hit;

        assign take_hit = take_en && (take_dst == DW'(d));
        assign ret_hit  = ret_en  && (ret_dst  == DW'(d));
        assign ovf_hit[d] = ret_hit && !take_hit && (cnt_q == FULL);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= FULL;
            end else if (take_hit && !ret_hit) begin
                cnt_q <= cnt_q - CW'(1);
            end else if (ret_hit && !take_hit && (cnt_q != FULL)) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end

        assign credit_flat[d*CW +: CW] = cnt_q;
        assign has_credit[d]           = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_err <= 1'b0;
        end else begin
            ovf_err <= |ovf_hit;
        end
    end
endmodule

// File: rtl/vsched_occ_bank.sv
module vsched_occ_bank
    import vsched_pkg::*;
#(
    parameter int unsigned N_DST = 4,
    parameter int unsigned OCC_W = 8,
    localparam int unsigned DW = (N_DST > 1) ? $clog2(N_DST) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 inc_en,
    input  logic [DW-1:0]                        inc_dst,
    input  logic [CLS_W-1:0]                     inc_cls,
    input  logic                                 dec_en,
    input  logic [DW-1:0]                        dec_dst,
    input  logic [CLS_W-1:0]                     dec_cls,
    output logic [NUM_CLS*N_DST*OCC_W-1:0]       occ_flat,
    output logic [NUM_CLS-1:0][N_DST-1:0]        nonempty
);
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        for (genvar d = 0; d < N_DST; d++) begin : g_dst
            logic [OCC_W-1:0] cnt_q;
            logic             up;
            logic             dn;

            assign up = inc_en && (inc_dst == DW'(d)) && (inc_cls == CLS_W'(c));
            assign dn = dec_en && (dec_dst == DW'(d)) && (dec_cls == CLS_W'(c));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (up && !dn) begin
                    cnt_q <= cnt_q + OCC_W'(1);
                end else if (dn && !up) begin
                    cnt_q <= cnt_q - OCC_W'(1);
                end
            end

            assign occ_flat[(c*N_DST + d)*OCC_W +: OCC_W] = cnt_q;
            assign nonempty[c][d] = (cnt_q != '0);
        end
    end
endmodule

// File: rtl/vsched_rr_pick.sv
module vsched_rr_pick #(
    parameter int unsigned N_DST = 4,
    localparam int unsigned DW = (N_DST > 1) ? $clog2(N_DST) : 1
) (
    input  logic [N_DST-1:0] mask,
    input  logic [DW-1:0]    ptr,
    output logic             found,
    output logic [DW-1:0]    idx
);
    always_comb begin
        int p;
        found = 1'b0;
        idx   = '0;
        p     = 0;
        for (int k = 0; k < N_DST; k++) begin
            p = (int'(ptr) + k) % N_DST;
            if (!found && mask[p]) begin
                found = 1'b1;
                idx   = DW'(p);
            end
        end
    end
endmodule

// File: rtl/vsched_ingress.sv
module vsched_ingress
    import vsched_pkg::*;
#(
    parameter int unsigned N_DST       = 4,
    parameter int unsigned CREDIT_INIT = 64,
    parameter int unsigned OCC_W       = 8,
    localparam int unsigned DW = (N_DST > 1) ? $clog2(N_DST) : 1,
    localparam int unsigned CW = $clog2(CREDIT_INIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [DW-1:0]    enq_dst,
    input  logic [CLS_W-1:0] enq_cls,
    input  logic             cred_valid,
    input  logic [DW-1:0]    cred_dst,
    input  logic             link_ready,
    output logic             grant_valid,
    output logic [DW-1:0]    grant_dst,
    output logic [CLS_W-1:0] grant_cls,
    output logic             cred_err
);
    logic [N_DST*CW-1:0]               credit_flat;
    logic [N_DST-1:0]                  has_credit;
    logic [NUM_CLS*N_DST*OCC_W-1:0]    occ_flat;
    logic [NUM_CLS-1:0][N_DST-1:0]     nonempty;
    logic [NUM_CLS-1:0][N_DST-1:0]     eligible;
    logic [NUM_CLS-1:0][DW-1:0]        ptr_q;
    logic [NUM_CLS-1:0][DW-1:0]        pick_dst;
    logic [NUM_CLS-1:0]                pick_ok;
    logic                              any_ok;
    logic [DW-1:0]                     win_dst;
    logic [CLS_W-1:0]                  win_cls;

    vsched_credit_bank #(
        .N_DST       (N_DST),
        .CREDIT_INIT (CREDIT_INIT)
    ) u_credit (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_en     (grant_valid),
        .take_dst    (grant_dst),
        .ret_en      (cred_valid),
        .ret_dst     (cred_dst),
        .credit_flat (credit_flat),
        .has_credit  (has_credit),
        .ovf_err     (cred_err)
    );

    vsched_occ_bank #(
        .N_DST (N_DST),
        .OCC_W (OCC_W)
    ) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (enq_valid),
        .inc_dst  (enq_dst),
        .inc_cls  (enq_cls),
        .dec_en   (grant_valid),
        .dec_dst  (grant_dst),
        .dec_cls  (grant_cls),
        .occ_flat (occ_flat),
        .nonempty (nonempty)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_class
        assign eligible[c] = nonempty[c] & has_credit;

        vsched_rr_pick #(.N_DST(N_DST)) u_pick (
            .mask  (eligible[c]),
            .ptr   (ptr_q[c]),
            .found (pick_ok[c]),
            .idx   (pick_dst[c])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[c] <= '0;
            end else if (grant_valid && (grant_cls == CLS_W'(c))) begin
                ptr_q[c] <= DW'((int'(grant_dst) + 1) % N_DST);
            end
        end
    end

    // strict priority: lowest class index with any eligible destination wins
    always_comb begin
        any_ok  = 1'b0;
        win_dst = '0;
        win_cls = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (!any_ok && pick_ok[c]) begin
                any_ok  = 1'b1;
                win_dst = pick_dst[c];
                win_cls = CLS_W'(c);
            end
        end
    end

    assign grant_valid = link_ready && any_ok;
    assign grant_dst   = win_dst;
    assign grant_cls   = win_cls;
endmodule

// File: rtl/vsched_ingress_chk.sv
module vsched_ingress_chk
    import vsched_pkg::*;
#(
    parameter int unsigned N_DST       = 4,
    parameter int unsigned CREDIT_INIT = 64,
    parameter int unsigned OCC_W       = 8,
    localparam int unsigned DW = (N_DST > 1) ? $clog2(N_DST) : 1,
    localparam int unsigned CW = $clog2(CREDIT_INIT + 1)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              link_ready,
    input logic                              cred_valid,
    input logic [DW-1:0]                     cred_dst,
    input logic                              grant_valid,
    input logic [DW-1:0]                     grant_dst,
    input logic [CLS_W-1:0]                  grant_cls,
    input logic                              cred_err,
    input logic [N_DST*CW-1:0]               credit_flat,
    input logic [NUM_CLS*N_DST*OCC_W-1:0]    occ_flat
);
    logic [CW-1:0]    gnt_cr;
    logic [CW-1:0]    ret_cr;
    logic [OCC_W-1:0] gnt_occ;
    logic             higher_busy;

    always_comb begin
        gnt_cr      = credit_flat[int'(grant_dst)*CW +: CW];
        ret_cr      = credit_flat[int'(cred_dst)*CW +: CW];
        gnt_occ     = occ_flat[(int'(grant_cls)*N_DST + int'(grant_dst))*OCC_W +: OCC_W];
        higher_busy = 1'b0;
        for (int c = 0; c < NUM_CLS; c++) begin
            for (int d = 0; d < N_DST; d++) begin
                if ((c < int'(grant_cls)) &&
                    (occ_flat[(c*N_DST + d)*OCC_W +: OCC_W] != '0) &&
                    (credit_flat[d*CW +: CW] != '0)) begin
                    higher_busy = 1'b1;
                end
            end
        end
    end

    a_r2_strict_prio: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !higher_busy);

    a_r3_credit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (gnt_cr != '0));

    a_r8_no_empty_grant: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (gnt_occ != '0));

    a_r9_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> link_ready);

    a_r6_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cred_valid && (ret_cr == CW'(CREDIT_INIT)) &&
         !(grant_valid && (grant_dst == cred_dst))) |=> cred_err);

    for (genvar d = 0; d < N_DST; d++) begin : g_pool_chk
        a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            credit_flat[d*CW +: CW] <= CW'(CREDIT_INIT));

        a_r4_take_one: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_valid && (grant_dst == DW'(d)) && !(cred_valid && (cred_dst == DW'(d))))
            |=> (credit_flat[d*CW +: CW] == CW'($past(credit_flat[d*CW +: CW]) - 1)));

        a_r7_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_valid && (grant_dst == DW'(d)) && cred_valid && (cred_dst == DW'(d)))
            |=> $stable(credit_flat[d*CW +: CW]));
    end
endmodule

bind vsched_ingress vsched_ingress_chk #(
    .N_DST       (N_DST),
    .CREDIT_INIT (CREDIT_INIT),
    .OCC_W       (OCC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_ready  (link_ready),
    .cred_valid  (cred_valid),
    .cred_dst    (cred_dst),
    .grant_valid (grant_valid),
    .grant_dst   (grant_dst),
    .grant_cls   (grant_cls),
    .cred_err    (cred_err),
    .credit_flat (credit_flat),
    .occ_flat    (occ_flat)
);

// File: tb/vsched_ingress_test.sv
`timescale 1ns/1ps
module vsched_ingress_test;
    localparam int N  = 4;
    localparam int DW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enq_valid;
    logic [DW-1:0] enq_dst;
    logic [2:0]    enq_cls;
    logic          cred_valid;
    logic [DW-1:0] cred_dst;
    logic          link_ready;
    logic          grant_valid;
    logic [DW-1:0] grant_dst;
    logic [2:0]    grant_cls;
    logic          cred_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    vsched_ingress uut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_dst(enq_dst), .enq_cls(enq_cls),
        .cred_valid(cred_valid), .cred_dst(cred_dst),
        .link_ready(link_ready),
        .grant_valid(grant_valid), .grant_dst(grant_dst), .grant_cls(grant_cls),
        .cred_err(cred_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive inputs after the falling edge, then settle before sampling
    task automatic tick(input bit ev, input int ed, input int ec,
                        input bit cv, input int cd, input bit rdy);
        @(negedge clk);
        enq_valid  = ev;  enq_dst  = DW'(ed); enq_cls = 3'(ec);
        cred_valid = cv;  cred_dst = DW'(cd); link_ready = rdy;
        #1;
    endtask

    task automatic expect_g(input string req, input bit v, input int d, input int c);
        bit ok;
        ok = (grant_valid == v) && (!v || ((grant_dst == DW'(d)) && (grant_cls == 3'(c))));
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s grant actual=%0b/d%0d/c%0d expected=%0b/d%0d/c%0d",
                     req, grant_valid, grant_dst, grant_cls, v, d, c);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        enq_valid = 0; enq_dst = 0; enq_cls = 0;
        cred_valid = 0; cred_dst = 0; link_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R1", 0, 0, 0);
        check(cred_err == 1'b0, "R1", "cred_err", cred_err, 0);
    endtask

    task automatic t_enqueue;
        tick(1, 1, 3, 0, 0, 0);             // one cell to d1 c3
        tick(0, 0, 0, 0, 0, 0);
        expect_g("R9", 0, 0, 0);            // held by link_ready low
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R8", 1, 1, 3);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R8", 0, 0, 0);            // queue drained
        // enqueue and grant on the same queue cancel
        tick(1, 0, 3, 0, 0, 0);
        tick(1, 0, 3, 0, 0, 1);
        expect_g("R8", 1, 0, 3);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R8", 1, 0, 3);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R8", 0, 0, 0);
    endtask

    task automatic t_priority;
        tick(1, 0, 5, 0, 0, 0);
        tick(1, 2, 1, 0, 0, 0);
        tick(1, 3, 7, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R2", 1, 2, 1);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R2", 1, 0, 5);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R2", 1, 3, 7);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R2", 0, 0, 0);
    endtask

    task automatic t_round_robin;
        for (int k = 0; k < 2 * N; k++) tick(1, k % N, 2, 0, 0, 0);
        for (int k = 0; k < 2 * N; k++) begin
            tick(0, 0, 0, 0, 0, 1);
            expect_g("R5", 1, k % N, 2);
        end
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R5", 0, 0, 0);
        // pointer of class 4 held at 0 through idle cycles without a grant
        tick(1, 2, 4, 0, 0, 0);
        tick(1, 0, 4, 0, 0, 0);
        repeat (3) begin
            tick(0, 0, 0, 0, 0, 0);
            expect_g("R9", 0, 0, 0);
        end
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R9", 1, 0, 4);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R9", 1, 2, 4);
    endtask

    // d1 has 64 - 3 = 61 credits left at this point
    task automatic t_exhaust;
        int cnt1;
        int seen6;
        bit stray;
        cnt1 = 0; seen6 = 0; stray = 0;
        for (int k = 0; k < 80; k++) tick(1, 1, 0, 0, 0, 0);
        tick(1, 2, 6, 0, 0, 0);
        for (int k = 0; k < 70; k++) begin
            tick(0, 0, 0, 0, 0, 1);
            if (grant_valid && grant_dst == 1 && grant_cls == 0) begin
                if (seen6 != 0) stray = 1;
                cnt1++;
            end else if (grant_valid && grant_dst == 2 && grant_cls == 6) seen6++;
            else if (grant_valid) stray = 1;
        end
        check(cnt1 == 61, "R3", "grants to d1 before credit runs out", cnt1, 61);
        check(seen6 == 1, "R3", "lower class served while d1 blocked", seen6, 1);
        check(!stray, "R3", "unexpected grant", stray, 0);
        // one credit back for d1: no grant that cycle, one the next
        tick(0, 0, 0, 1, 1, 1);
        expect_g("R4", 0, 0, 0);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R4", 1, 1, 0);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R4", 0, 0, 0);
    endtask

    task automatic t_same_cycle;
        tick(0, 0, 0, 1, 1, 1);             // credit 0 -> 1
        expect_g("R7", 0, 0, 0);
        tick(0, 0, 0, 1, 1, 1);             // grant and return together
        expect_g("R7", 1, 1, 0);
        tick(0, 0, 0, 0, 0, 1);             // still one credit
        expect_g("R7", 1, 1, 0);
        tick(0, 0, 0, 0, 0, 1);
        expect_g("R7", 0, 0, 0);
    endtask

    // d3 has 64 - 3 = 61 credits left at this point
    task automatic t_overflow;
        int cnt3;
        cnt3 = 0;
        for (int k = 0; k < 3; k++) begin
            tick(0, 0, 0, 1, 3, 0);
            check(cred_err == 1'b0, "R6", "cred_err below cap", cred_err, 0);
        end
        tick(0, 0, 0, 1, 3, 0);             // pool is full: discarded
        check(cred_err == 1'b0, "R6", "cred_err before flag", cred_err, 0);
        tick(0, 0, 0, 0, 0, 0);
        check(cred_err == 1'b1, "R6", "cred_err after discard", cred_err, 1);
        tick(0, 0, 0, 0, 0, 0);
        check(cred_err == 1'b0, "R6", "cred_err one cycle only", cred_err, 0);
        for (int k = 0; k < 70; k++) tick(1, 3, 0, 0, 0, 0);
        for (int k = 0; k < 80; k++) begin
            tick(0, 0, 0, 0, 0, 1);
            if (grant_valid && grant_dst == 3) cnt3++;
        end
        // full pool equals CREDIT_INIT (R1) and was not raised past it
        check(cnt3 == 64, "R6", "grants to d3 from a full pool", cnt3, 64);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_enqueue();
        t_priority();
        t_round_robin();
        t_exhaust();
        t_same_cycle();
        t_overflow();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule